// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two predictors and a chooser. The local predictor keeps a short outcome history for each branch slot, selected by low bits of the branch address, and uses that history to index a table of 2-bit saturating counters. The global predictor indexes its own counter table with the outcomes of the most recent branches. The chooser is a third counter table, indexed by the same global history, that decides which of the two predictions is returned.

A lookup is combinational. The front end presents a branch address and gets back the final direction, both component directions and the indices that were used. The caller carries these values with the branch down the pipeline. When the branch retires, the caller returns them together with the resolved outcome on the update port. The tables and histories change on the clock edge at which the update is presented. Both histories advance only with resolved outcomes. Branches that share a history slot simply share its contents, with no tag check. Target prediction is not part of the block.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every local history slot and the global history read zero, both counter tables hold 2'b01 (weakly not taken) and every chooser entry holds 2'b10 (weakly prefer global). A lookup after reset therefore returns not taken from every source, with lhist 0 and ghist 0.
- R2: The local history slot used by a lookup is lk_pc[5:2], reported on lk_lht_idx. Addresses that agree in bits 5..2 share one slot.
- R3: On an update, local history slot up_lht_idx becomes its previous value shifted left by one, with up_taken in bit 0 (bit 0 is the newest outcome).
- R4: On an update, the global history shifts left by one with up_taken in bit 0. Without an update it holds its value.
- R5: Every counter is a 2-bit saturating counter that predicts taken when its value is 2 or 3. A taken outcome adds one, stopping at 3. A not-taken outcome subtracts one, stopping at 0.
- R6: Every update trains the local counter at up_lhist and the global counter at up_ghist with up_taken, whichever component was chosen.
- R7: The chooser entry at up_ghist changes only when up_local_taken differs from up_global_taken. It then steps toward global (up) if the global prediction matched up_taken, and toward local (down) otherwise.
- R8: The final prediction is the global prediction when bit 1 of the chooser entry at the current global history is set, and the local prediction otherwise.
- R9: Lookup outputs depend combinationally on lk_pc and the stored state. An update presented in a cycle is first visible to lookups after the next rising clock edge.
- R10: A branch that repeats a taken, taken, taken, not-taken pattern is predicted without error by the local component once its history has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_taken | output | 1 | Final predicted direction |
| lk_local_taken | output | 1 | Local component prediction |
| lk_global_taken | output | 1 | Global component prediction |
| lk_lht_idx | output | 4 | Local history slot used |
| lk_lhist | output | 10 | Local history read, used as local counter index |
| lk_ghist | output | 12 | Global history, used as global counter and chooser index |
| up_valid | input | 1 | A retired branch is presented this cycle |
| up_taken | input | 1 | Resolved direction of the retired branch |
| up_local_taken | input | 1 | Saved local prediction |
| up_global_taken | input | 1 | Saved global prediction |
| up_lht_idx | input | 4 | Saved local history slot |
| up_lhist | input | 10 | Saved local history |
| up_ghist | input | 12 | Saved global history |

## Verification
The hardest state to reach from the ports is a chooser entry that has moved toward local. For that, one global history value must be seen by branches that go opposite ways, and the global predictor must be wrong while the local one is right. The stimulus places one always-not-taken branch between long runs of always-taken filler branches. The history in front of the not-taken branch is then all ones, the same as for the fillers. The global counter there stays taken while the local side of the lone branch learns not taken. A reference model in the bench follows every table through the whole sequence, and a final lookup confirms that the local prediction wins.

// File: rtl/tour_pkg.sv
package tour_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_WEAK_T  = 2'b10;

  // Saturating step of a 2-bit counter toward taken (up) or not taken.
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  // Direction implied by a counter: its upper bit.
  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/sat_ctr_table.sv
module sat_ctr_table
  import tour_pkg::*;
#(
  parameter int   IDX_W = 10,
  parameter ctr_t INIT  = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl_q [DEPTH];
  ctr_t wr_old;

  assign rd_ctr = tbl_q[rd_idx];
  assign wr_old = tbl_q[wr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= INIT;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= ctr_step(wr_old, wr_up);
    end
  end

  // R5: no wrap at the top
  p_sat_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && wr_old == 2'b11) |=> tbl_q[$past(wr_idx)] == 2'b11);

  // R5: no wrap at the bottom
  p_sat_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && wr_old == 2'b00) |=> tbl_q[$past(wr_idx)] == 2'b00);

  // R7: without a write, the entry being read keeps its value
  p_no_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> tbl_q[$past(rd_idx)] == $past(rd_ctr));

endmodule

// File: rtl/local_hist_table.sv
module local_hist_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [ENTRIES];
  logic [HIST_W-1:0] wr_old;

  assign rd_hist = hist_q[rd_idx];
  assign wr_old  = hist_q[wr_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[wr_idx] <= {wr_old[HIST_W-2:0], wr_bit};
    end
  end

  // R3: the written slot holds the old history shifted, outcome in bit 0
  p_lhist_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> hist_q[$past(wr_idx)][0] == $past(wr_bit));

  // R3: untouched slot being read stays put
  p_lhist_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_idx != rd_idx) |=> hist_q[$past(rd_idx)] == $past(rd_hist));

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
  import tour_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int LHT_LSB   = 2,
  parameter int LHT_IDX_W = 4,
  parameter int LHIST_W   = 10,
  parameter int GHIST_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      lk_pc,
  output logic                 lk_taken,
  output logic                 lk_local_taken,
  output logic                 lk_global_taken,
  output logic [LHT_IDX_W-1:0] lk_lht_idx,
  output logic [LHIST_W-1:0]   lk_lhist,
  output logic [GHIST_W-1:0]   lk_ghist,
  input  logic                 up_valid,
  input  logic                 up_taken,
  input  logic                 up_local_taken,
  input  logic                 up_global_taken,
  input  logic [LHT_IDX_W-1:0] up_lht_idx,
  input  logic [LHIST_W-1:0]   up_lhist,
  input  logic [GHIST_W-1:0]   up_ghist
);

  logic [GHIST_W-1:0] ghr_q;
  ctr_t               local_ctr;
  ctr_t               global_ctr;
  ctr_t               choice_ctr;
  logic               pick_global;
  logic               comp_disagree;
  logic               chooser_train;
  logic               global_was_right;
  logic               unused_pc_bits;

  assign unused_pc_bits = ^lk_pc;

  assign lk_lht_idx = lk_pc[LHT_LSB +: LHT_IDX_W];
  assign lk_ghist   = ghr_q;

  local_hist_table #(
    .IDX_W (LHT_IDX_W),
    .HIST_W(LHIST_W)
  ) u_lht (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lk_lht_idx),
    .rd_hist(lk_lhist),
    .wr_en  (up_valid),
    .wr_idx (up_lht_idx),
    .wr_bit (up_taken)
  );

  sat_ctr_table #(
    .IDX_W(LHIST_W),
    .INIT (CTR_WEAK_NT)
  ) u_local_pht (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_idx(lk_lhist),
    .rd_ctr(local_ctr),
    .wr_en (up_valid),
    .wr_idx(up_lhist),
    .wr_up (up_taken)
  );

  sat_ctr_table #(
    .IDX_W(GHIST_W),
    .INIT (CTR_WEAK_NT)
  ) u_global_pht (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_idx(ghr_q),
    .rd_ctr(global_ctr),
    .wr_en (up_valid),
    .wr_idx(up_ghist),
    .wr_up (up_taken)
  );

  assign comp_disagree    = up_local_taken != up_global_taken;
  assign chooser_train    = up_valid && comp_disagree;
  assign global_was_right = up_global_taken == up_taken;

  sat_ctr_table #(
    .IDX_W(GHIST_W),
    .INIT (CTR_WEAK_T)
  ) u_chooser (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_idx(ghr_q),
    .rd_ctr(choice_ctr),
    .wr_en (chooser_train),
    .wr_idx(up_ghist),
    .wr_up (global_was_right)
  );

  assign lk_local_taken  = ctr_dir(local_ctr);
  assign lk_global_taken = ctr_dir(global_ctr);
  assign pick_global     = ctr_dir(choice_ctr);
  assign lk_taken        = pick_global ? lk_global_taken : lk_local_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ghr_q <= '0;
    else if (up_valid) ghr_q <= {ghr_q[GHIST_W-2:0], up_taken};
  end

  // R4: global history takes the retired outcome as its newest bit
  p_ghr_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghr_q[0] == $past(up_taken) &&
                 ghr_q[GHIST_W-1:1] == $past(ghr_q[GHIST_W-2:0]));

  // R4: no update, no history movement
  p_ghr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghr_q));

  // R8: when both components agree, the final answer is that direction
  p_agree_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_local_taken == lk_global_taken) |-> lk_taken == lk_local_taken);

endmodule

// File: tb/test_tournament_predictor.sv
module test_tournament_predictor;

  localparam int LI = 4;
  localparam int LH = 10;
  localparam int GH = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   lk_pc = '0;
  logic          lk_taken, lk_local_taken, lk_global_taken;
  logic [LI-1:0] lk_lht_idx;
  logic [LH-1:0] lk_lhist;
  logic [GH-1:0] lk_ghist;
  logic          up_valid = 1'b0, up_taken = 1'b0;
  logic          up_local_taken = 1'b0, up_global_taken = 1'b0;
  logic [LI-1:0] up_lht_idx = '0;
  logic [LH-1:0] up_lhist = '0;
  logic [GH-1:0] up_ghist = '0;

  always #5 clk = ~clk;

  tournament_predictor i_tournament_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
    .lk_taken(lk_taken), .lk_local_taken(lk_local_taken),
    .lk_global_taken(lk_global_taken), .lk_lht_idx(lk_lht_idx),
    .lk_lhist(lk_lhist), .lk_ghist(lk_ghist),
    .up_valid(up_valid), .up_taken(up_taken),
    .up_local_taken(up_local_taken), .up_global_taken(up_global_taken),
    .up_lht_idx(up_lht_idx), .up_lhist(up_lhist), .up_ghist(up_ghist)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [1:0]    m_lpht [1 << LH];
  logic [1:0]    m_gpht [1 << GH];
  logic [1:0]    m_ch   [1 << GH];
  logic [LH-1:0] m_lht  [1 << LI];
  logic [GH-1:0] m_ghr;

  function automatic logic [1:0] sat_move(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    up_valid = 1'b0;
    for (int i = 0; i < (1 << LH); i++) m_lpht[i] = 2'b01;
    for (int i = 0; i < (1 << GH); i++) begin
      m_gpht[i] = 2'b01;
      m_ch[i]   = 2'b10;
    end
    for (int i = 0; i < (1 << LI); i++) m_lht[i] = '0;
    m_ghr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One branch: lookup, compare against the model, then retire it.
  task automatic branch(input logic [31:0] pc, input logic tk, input string req,
                        output logic local_ok);
    logic [LI-1:0] i;
    logic [LH-1:0] h;
    logic [GH-1:0] g;
    logic pl, pg, pf;
    @(negedge clk);
    lk_pc = pc;
    #1;
    i  = pc[5:2];
    h  = m_lht[i];
    g  = m_ghr;
    pl = m_lpht[h][1];
    pg = m_gpht[g][1];
    pf = m_ch[g][1] ? pg : pl;
    chk(req, "lht index", lk_lht_idx, i);
    chk(req, "local history", lk_lhist, h);
    chk(req, "global history", lk_ghist, g);
    chk(req, "local pred", lk_local_taken, pl);
    chk(req, "global pred", lk_global_taken, pg);
    chk(req, "final pred", lk_taken, pf);
    up_taken        = tk;
    up_local_taken  = lk_local_taken;
    up_global_taken = lk_global_taken;
    up_lht_idx      = lk_lht_idx;
    up_lhist        = lk_lhist;
    up_ghist        = lk_ghist;
    up_valid        = 1'b1;
    @(posedge clk);
    #1;
    up_valid = 1'b0;
    m_lpht[h] = sat_move(m_lpht[h], tk);
    m_gpht[g] = sat_move(m_gpht[g], tk);
    if (pl != pg) m_ch[g] = sat_move(m_ch[g], pg == tk);
    m_lht[i] = {h[LH-2:0], tk};
    m_ghr    = {g[GH-2:0], tk};
    local_ok = (pl == tk);
  endtask

  task automatic peek(input logic [31:0] pc, output logic l, output logic g,
                      output logic f, output logic [LI-1:0] ix,
                      output logic [LH-1:0] h, output logic [GH-1:0] gh);
    @(negedge clk);
    lk_pc = pc;
    #1;
    l = lk_local_taken; g = lk_global_taken; f = lk_taken;
    ix = lk_lht_idx; h = lk_lhist; gh = lk_ghist;
  endtask

  task automatic t_reset_state();
    logic l, g, f; logic [LI-1:0] ix; logic [LH-1:0] h; logic [GH-1:0] gh;
    do_reset();
    foreach (m_lht[k]) begin
      peek(32'(k) << 2, l, g, f, ix, h, gh);
      chk("R1", "reset local history", h, 0);
    end
    peek(32'h0000_1234, l, g, f, ix, h, gh);
    chk("R1", "reset local pred", l, 0);
    chk("R1", "reset global pred", g, 0);
    chk("R1", "reset final pred", f, 0);
    chk("R1", "reset global history", gh, 0);
  endtask

  task automatic t_index_alias();
    logic ok, l, g, f; logic [LI-1:0] ix; logic [LH-1:0] h; logic [GH-1:0] gh;
    do_reset();
    branch(32'h0000_0010, 1'b1, "R3", ok);
    branch(32'h0000_0010, 1'b0, "R3", ok);
    branch(32'h0000_0010, 1'b1, "R3", ok);
    peek(32'h0000_1010, l, g, f, ix, h, gh);
    chk("R2", "alias slot index", ix, 4);
    chk("R3", "aliased history 101", h, 5);
    peek(32'h0000_0014, l, g, f, ix, h, gh);
    chk("R2", "neighbour slot index", ix, 5);
    chk("R2", "neighbour history untouched", h, 0);
  endtask

  task automatic t_global_hist();
    logic ok, l, g, f; logic [LI-1:0] ix; logic [LH-1:0] h; logic [GH-1:0] gh;
    do_reset();
    branch(32'h0000_0100, 1'b1, "R4", ok);
    branch(32'h0000_0204, 1'b1, "R4", ok);
    branch(32'h0000_0308, 1'b0, "R4", ok);
    branch(32'h0000_040C, 1'b1, "R4", ok);
    peek(32'h0, l, g, f, ix, h, gh);
    chk("R4", "global history 1101", gh, 13);
    repeat (3) @(negedge clk);
    peek(32'h0, l, g, f, ix, h, gh);
    chk("R4", "global history holds when idle", gh, 13);
  endtask

  task automatic t_saturation();
    logic ok, l, g, f; logic [LI-1:0] ix; logic [LH-1:0] h; logic [GH-1:0] gh;
    do_reset();
    for (int n = 0; n < 3; n++) branch(32'h0, 1'b0, "R5", ok);
    branch(32'h0, 1'b1, "R5", ok);
    peek(32'h4, l, g, f, ix, h, gh);
    chk("R5", "low end holds at 0 then steps to 1", l, 0);
    do_reset();
    for (int n = 0; n < 20; n++) branch(32'h4, 1'b1, "R5", ok);
    for (int n = 0; n < 10; n++) branch(32'h8, 1'b1, "R5", ok);
    branch(32'h8, 1'b0, "R5", ok);
    peek(32'h4, l, g, f, ix, h, gh);
    chk("R5", "high end holds at 3 then steps to 2", l, 1);
  endtask

  task automatic t_both_train();
    logic ok, l, g, f; logic [LI-1:0] ix; logic [LH-1:0] h; logic [GH-1:0] gh;
    do_reset();
    branch(32'h0, 1'b1, "R6", ok);
    peek(32'h4, l, g, f, ix, h, gh);
    chk("R6", "unchosen local counter trained", l, 1);
    chk("R8", "weak-global chooser picks global", f, 0);
    for (int n = 0; n < GH; n++) branch(32'h8, 1'b0, "R6", ok);
    peek(32'h8, l, g, f, ix, h, gh);
    chk("R6", "global history back to 0", gh, 0);
    chk("R6", "global counter trained", g, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    @(negedge clk);
    lk_pc = 32'h10;
    up_lht_idx = 4'd4; up_lhist = '0; up_ghist = '0;
    up_taken = 1'b1; up_local_taken = 1'b0; up_global_taken = 1'b0;
    up_valid = 1'b1;
    #1;
    chk("R9", "old local history before edge", lk_lhist, 0);
    chk("R9", "old global history before edge", lk_ghist, 0);
    @(posedge clk);
    #1;
    up_valid = 1'b0;
    #1;
    chk("R9", "new local history after edge", lk_lhist, 1);
    chk("R9", "new global history after edge", lk_ghist, 1);
  endtask

  task automatic t_loop_learn();
    logic ok;
    int   miss;
    do_reset();
    miss = 0;
    for (int it = 0; it < 30; it++) begin
      for (int s = 0; s < 4; s++) begin
        branch(32'h20, (s != 3), "R10", ok);
        if (it >= 20 && !ok) miss++;
      end
    end
    chk("R10", "local mispredicts on period-4 loop", miss, 0);
  endtask

  task automatic t_chooser_shift();
    logic ok, l, g, f; logic [LI-1:0] ix; logic [LH-1:0] h; logic [GH-1:0] gh;
    do_reset();
    for (int n = 0; n < GH; n++) branch(32'hC, 1'b1, "R7", ok);
    for (int r = 0; r < 8; r++) begin
      branch(32'h4, 1'b1, "R7", ok);
      for (int n = 0; n < GH; n++) branch(32'hC, 1'b1, "R7", ok);
      branch(32'h8, 1'b0, "R7", ok);
      for (int n = 0; n < GH; n++) branch(32'hC, 1'b1, "R7", ok);
    end
    peek(32'h8, l, g, f, ix, h, gh);
    chk("R7", "history before lone branch all ones", gh, 4095);
    chk("R7", "local says not taken", l, 0);
    chk("R7", "global says taken", g, 1);
    chk("R8", "chooser now follows local", f, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_index_alias();
    t_global_hist();
    t_saturation();
    t_both_train();
    t_same_cycle();
    t_loop_learn();
    t_chooser_shift();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule